// File: doc/BRIEF.md
# Asynchronous Byte-Wide SRAM Access Controller

This block sits between an on-chip, clock-synchronous request port and an external asynchronous static RAM of 32768 bytes. A requester offers one access at a time: a read or a write to a 15-bit byte address. The controller registers the request and plays out a fixed sequence of chip-enable, output-enable and write-enable levels on the memory pins, each held for a whole number of clock cycles. For a read it returns the byte together with a one-cycle valid strobe.

The memory data bus is bidirectional. At the block edge it is split into an outgoing byte, an incoming byte and a drive-enable for the pad. The controller turns its drivers on only while the memory cannot be driving. Each write request chooses one of two write styles. In the first, output enable stays high and data is driven for the whole write. In the second, output enable stays low throughout the write, so the controller first waits for the memory to release the bus after write enable falls, and only then drives data for the setup time before write enable rises. Phase lengths are parameters given in clock cycles. A parameter set below one cycle is raised to one.

Top module: `asram_ctrl`

## Requirements
- R1: While idle, `req_ready` is 1, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, and `mem_dq_oe` is 0. This is also the state after reset.
- R2: A read is accepted at a clock edge where `req_valid` and `req_ready` are both 1 and `req_write` is 0. For RD_CYC cycles (default 2) the memory sees `mem_ce_n`=0, `mem_oe_n`=0 and `mem_we_n`=1. The byte on `mem_dq_in` in the last of those cycles appears on `rd_data`, with `rd_valid` high for exactly one cycle, RD_CYC cycles after the accepting edge.
- R3: A write with `req_oe_low`=0 at acceptance uses these cycles, counted from the accepting edge: WR_SETUP_CYC (default 1) with `mem_we_n`=1, then WR_PULSE_CYC (default 2) with `mem_we_n`=0, then WR_HOLD_CYC (default 1) with `mem_we_n`=1. Throughout, `mem_ce_n`=0, `mem_oe_n`=1 and `mem_dq_oe`=1. The written byte is then stored at the address.
- R4: A write with `req_oe_low`=1 at acceptance holds `mem_ce_n`=0 and `mem_oe_n`=0 throughout. It uses the cycles in this order: setup with `mem_we_n`=1 and drivers off; WE_HIZ_CYC (default 1) with `mem_we_n`=0 and drivers off; DATA_SU_CYC (default 1) with `mem_we_n`=0 and `mem_dq_oe`=1; then hold with `mem_we_n`=1 and drivers off. `mem_dq_oe` is always 1 in the cycle before `mem_we_n` rises.
- R5: `mem_dq_oe` is never 1 in a cycle where `mem_ce_n`=0, `mem_oe_n`=0 and `mem_we_n`=1, which is the condition under which the memory drives.
- R6: While `mem_ce_n` stays low, `mem_addr` and `mem_dq_out` do not change. `mem_addr` never changes across two consecutive cycles in which `mem_we_n` is low.
- R7: `mem_dq_oe` never rises in the cycle right after a cycle in which `mem_oe_n` was 0 and `mem_we_n` was 1. A write that follows a read is therefore separated from it by at least one cycle with output enable high.
- R8: The write style is taken from `req_oe_low` only at the accepting edge. Changes on `req_oe_low` during the access have no effect on the pin sequence.
- R9: `req_ready` is 0 from the accepting edge until the access ends. For reads it returns with `rd_valid`; for writes it returns 4 cycles after acceptance with the defaults. Changes on `req_addr` and `req_wdata` while busy have no effect on the stored data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_write | input | 1 | 1 = write, 0 = read |
| req_oe_low | input | 1 | Write style: 1 = output enable held low during the write |
| req_addr | input | 15 | Byte address |
| req_wdata | input | 8 | Byte to write |
| req_ready | output | 1 | Controller idle and able to accept |
| rd_valid | output | 1 | One-cycle strobe: `rd_data` holds read result |
| rd_data | output | 8 | Read result |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | 15 | Memory address |
| mem_dq_out | output | 8 | Byte driven toward the memory data pins |
| mem_dq_oe | output | 1 | Enable for the controller's data drivers |
| mem_dq_in | input | 8 | Byte seen on the memory data pins |

## Verification
With the default lengths, the read result and its strobe are due exactly 2 cycles after the accepting edge, and a write keeps the controller busy for exactly 4 cycles, which show one fixed pin pattern per write style. The bench keeps a cycle counter, tags every expected read with its due cycle in a scoreboard queue, and compares data and arrival cycle when the strobe appears. For writes, it records the four pin cycles after acceptance and compares them against the pattern for the style. All samples are taken on the falling clock edge, half a cycle after the registered outputs change, and a pin-level memory model in the bench stores bytes only at the end of the write-enable/chip-enable overlap.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the asynchronous SRAM access controller.
// Assumes nothing beyond SystemVerilog constant-function evaluation.
package asram_pkg;

    // Access phases; every access returns to PH_IDLE before the next one.
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_READ,
        PH_WSETUP,
        PH_WHIZ,
        PH_WDRIVE,
        PH_WHOLD
    } asram_phase_e;

    // Raise a cycle count to the one-cycle minimum.
    function automatic int unsigned at_least_one(input int unsigned v);
        return (v < 1) ? 1 : v;
    endfunction

    // Larger of two counts.
    function automatic int unsigned bigger(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_phase_timer.sv
`timescale 1ns/1ps
// Down-counter that times one access phase.
// Loaded with (length - 1) on entry to a phase; done is high in the phase's
// last cycle. Assumes the loader never loads while a phase is still running.
module asram_phase_timer #(
    parameter int unsigned CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] len_m1,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    // Count down to zero, reload on phase entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= len_m1;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/asram_seq.sv
`timescale 1ns/1ps
// Phase sequencer: walks read and write accesses through their phases and
// produces the memory control levels and the data-driver enable.
// All pin levels are registered from the next phase, so the strobes cannot
// glitch. Assumes the requester offers a new access only when ready is high.
module asram_seq
    import asram_pkg::*;
#(
    parameter int unsigned RD_CYC       = 2,
    parameter int unsigned WR_SETUP_CYC = 1,
    parameter int unsigned WR_PULSE_CYC = 2,
    parameter int unsigned WR_HOLD_CYC  = 1,
    parameter int unsigned WE_HIZ_CYC   = 1,
    parameter int unsigned DATA_SU_CYC  = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_write,
    input  logic req_oe_low,
    output logic req_ready,
    output logic accept,
    output logic rd_capture,
    output logic mem_ce_n,
    output logic mem_oe_n,
    output logic mem_we_n,
    output logic dq_drive
);

    localparam int unsigned RD_LEN  = at_least_one(RD_CYC);
    localparam int unsigned SU_LEN  = at_least_one(WR_SETUP_CYC);
    localparam int unsigned PW_LEN  = at_least_one(WR_PULSE_CYC);
    localparam int unsigned HD_LEN  = at_least_one(WR_HOLD_CYC);
    localparam int unsigned HZ_LEN  = at_least_one(WE_HIZ_CYC);
    localparam int unsigned DS_LEN  = at_least_one(DATA_SU_CYC);
    localparam int unsigned MAX_LEN = bigger(bigger(bigger(RD_LEN, SU_LEN), bigger(PW_LEN, HD_LEN)),
                                             bigger(HZ_LEN, DS_LEN));
    localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);

    asram_phase_e     state_q, state_d;
    logic             style_q, style_d;
    logic             load, done;
    int unsigned      phase_len;
    logic [CNT_W-1:0] len_m1;

    assign req_ready  = (state_q == PH_IDLE);
    assign accept     = req_valid && req_ready;
    assign style_d    = accept ? req_oe_low : style_q;
    assign rd_capture = (state_q == PH_READ) && done;

    // Next phase from the current phase and the timer.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE:   if (req_valid) state_d = req_write ? PH_WSETUP : PH_READ;
            PH_READ:   if (done) state_d = PH_IDLE;
            PH_WSETUP: if (done) state_d = style_q ? PH_WHIZ : PH_WDRIVE;
            PH_WHIZ:   if (done) state_d = PH_WDRIVE;
            PH_WDRIVE: if (done) state_d = PH_WHOLD;
            PH_WHOLD:  if (done) state_d = PH_IDLE;
            default:   state_d = PH_IDLE;
        endcase
    end

    // Length of the phase being entered.
    always_comb begin
        unique case (state_d)
            PH_READ:   phase_len = RD_LEN;
            PH_WSETUP: phase_len = SU_LEN;
            PH_WHIZ:   phase_len = HZ_LEN;
            PH_WDRIVE: phase_len = style_d ? DS_LEN : PW_LEN;
            PH_WHOLD:  phase_len = HD_LEN;
            default:   phase_len = 1;
        endcase
        len_m1 = CNT_W'(phase_len - 1);
    end

    assign load = (state_d != state_q) && (state_d != PH_IDLE);

    asram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .len_m1 (len_m1),
        .done   (done)
    );

    // Phase register and write style held for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
            style_q <= 1'b0;
        end else begin
            state_q <= state_d;
            style_q <= style_d;
        end
    end

    // Registered pin levels decoded from the phase being entered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_ce_n <= 1'b1;
            mem_oe_n <= 1'b1;
            mem_we_n <= 1'b1;
            dq_drive <= 1'b0;
        end else begin
            mem_ce_n <= (state_d == PH_IDLE);
            mem_oe_n <= !((state_d == PH_READ) ||
                          (style_d && (state_d inside {PH_WSETUP, PH_WHIZ, PH_WDRIVE, PH_WHOLD})));
            mem_we_n <= !(state_d inside {PH_WHIZ, PH_WDRIVE});
            dq_drive <= style_d ? (state_d == PH_WDRIVE)
                                : (state_d inside {PH_WSETUP, PH_WDRIVE, PH_WHOLD});
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !dq_drive)); // R1
    AST_CAPTURE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_capture |-> (!mem_ce_n && !mem_oe_n && mem_we_n)); // R2
    AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_ce_n); // R3
    AST_DATA_AT_WRITE_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> $past(dq_drive)); // R4
    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        !(dq_drive && !mem_ce_n && !mem_oe_n && mem_we_n)); // R5
    AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_drive) |-> ($past(mem_oe_n) || !$past(mem_we_n))); // R7

endmodule

// File: rtl/asram_dpath.sv
`timescale 1ns/1ps
// Data path: registers address and write byte at acceptance and captures
// the read byte on the sequencer's capture pulse.
// Assumes accept and rd_capture come from the sequencer in the same clock.
module asram_dpath #(
    parameter int unsigned ADDR_W = 15,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              rd_capture,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    // Request fields held for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
        end else if (accept) begin
            mem_addr   <= req_addr;
            mem_dq_out <= req_wdata;
        end
    end

    // Read byte capture and its one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_capture;
            if (rd_capture) rd_data <= mem_dq_in;
        end
    end

endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
// Top of the asynchronous SRAM access controller: a request port on one side,
// chip/output/write enables, address and a split data bus on the other.
// Assumes a requester that waits for req_ready and a pad that drives
// mem_dq_out onto the memory pins while mem_dq_oe is high.
module asram_ctrl #(
    parameter int unsigned ADDR_W       = 15,
    parameter int unsigned DATA_W       = 8,
    parameter int unsigned RD_CYC       = 2,
    parameter int unsigned WR_SETUP_CYC = 1,
    parameter int unsigned WR_PULSE_CYC = 2,
    parameter int unsigned WR_HOLD_CYC  = 1,
    parameter int unsigned WE_HIZ_CYC   = 1,
    parameter int unsigned DATA_SU_CYC  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_oe_low,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    logic accept;
    logic rd_capture;

    asram_seq #(
        .RD_CYC       (RD_CYC),
        .WR_SETUP_CYC (WR_SETUP_CYC),
        .WR_PULSE_CYC (WR_PULSE_CYC),
        .WR_HOLD_CYC  (WR_HOLD_CYC),
        .WE_HIZ_CYC   (WE_HIZ_CYC),
        .DATA_SU_CYC  (DATA_SU_CYC)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_oe_low (req_oe_low),
        .req_ready  (req_ready),
        .accept     (accept),
        .rd_capture (rd_capture),
        .mem_ce_n   (mem_ce_n),
        .mem_oe_n   (mem_oe_n),
        .mem_we_n   (mem_we_n),
        .dq_drive   (mem_dq_oe)
    );

    asram_dpath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dpath (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .rd_capture (rd_capture),
        .mem_dq_in  (mem_dq_in),
        .mem_addr   (mem_addr),
        .mem_dq_out (mem_dq_out),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data)
    );

    AST_ACCESS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && !$past(mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out))); // R6
    AST_ADDR_UNDER_WE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && !$past(mem_we_n)) |-> $stable(mem_addr)); // R6

endmodule

// File: tb/asram_ctrl_tb.sv
`timescale 1ns/1ps
// Scoreboard bench for asram_ctrl with a pin-level asynchronous SRAM model.
module asram_ctrl_tb;

    localparam int RD_CYC = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_oe_low = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rd_valid;
    logic [7:0]  rd_data;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [14:0] mem_addr;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = 8'h5A;

    always #2.5 clk = ~clk;

    asram_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_oe_low(req_oe_low), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    typedef struct packed {
        logic [7:0] data;
        int         due;
    } exp_t;

    exp_t       exp_q[$];
    logic [7:0] ref_mem [int];
    logic [7:0] mdl_mem [int];
    int         total = 0, bad = 0, cyc = 0;
    bit         finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] ref_rd(input int a);
        return ref_mem.exists(a) ? ref_mem[a] : 8'h00;
    endfunction

    function automatic logic [7:0] mdl_rd(input int a);
        return mdl_mem.exists(a) ? mdl_mem[a] : 8'h00;
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // Monitor: memory model, pin rules and read scoreboard, sampled on the falling edge.
    logic        prev_act = 0, prev_oe_n = 1, prev_we_n = 1, prev_dq = 0, pend_ok = 0;
    logic [14:0] prev_addr = '0, pend_a = '0;
    logic [7:0]  pend_d = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            logic act, drive;
            exp_t e;
            act = !mem_ce_n && !mem_we_n;
            if (act && mem_dq_oe) begin
                pend_d = mem_dq_out; pend_a = mem_addr; pend_ok = 1;
            end
            if (prev_act && !act) begin
                chk(pend_ok, "R3", "data driven before write end", 0, 1);
                if (pend_ok) mdl_mem[int'(pend_a)] = pend_d;
                pend_ok = 0;
            end
            drive = !mem_ce_n && !mem_oe_n && mem_we_n;
            if (drive && mem_dq_oe) chk(0, "R5", "bus contention", 1, 0);
            if (mem_dq_oe && !prev_dq && !prev_oe_n && prev_we_n)
                chk(0, "R7", "driver on right after output enable low", 1, 0);
            if (!mem_we_n && !prev_we_n && mem_addr != prev_addr)
                chk(0, "R6", "address moved under write enable", int'(mem_addr), int'(prev_addr));
            if (rd_valid) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R2", "unexpected read strobe", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(rd_data == e.data, "R2", "read data", int'(rd_data), int'(e.data));
                    chk(cyc == e.due, "R2", "read strobe cycle", cyc, e.due);
                    chk(req_ready == 1'b1, "R9", "ready with read strobe", int'(req_ready), 1);
                end
            end
            mem_dq_in = drive ? mdl_rd(int'(mem_addr)) : 8'h5A;
            prev_act = act; prev_oe_n = mem_oe_n; prev_we_n = mem_we_n;
            prev_dq = mem_dq_oe; prev_addr = mem_addr;
        end
    end

    // Driver: issue one access (called at a falling edge), push expectations,
    // check the write pin pattern. Scribbles on request fields while busy.
    task automatic issue(input bit wr, input logic [14:0] a, input logic [7:0] d, input bit st);
        logic [3:0] we_p, oe_p, dq_p, ce_p, rdy_p;
        int acc;
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_oe_low = st;
        @(posedge clk); #1; acc = cyc;
        @(negedge clk);
        req_valid = 0; req_write = ~wr; req_addr = ~a; req_wdata = ~d; req_oe_low = ~st;
        if (!wr) begin
            exp_q.push_back('{data: ref_rd(int'(a)), due: acc + RD_CYC});
            chk(!req_ready, "R9", "busy after read accept", int'(req_ready), 0);
        end else begin
            ref_mem[int'(a)] = d;
            for (int i = 0; i < 4; i++) begin
                we_p[i] = mem_we_n; oe_p[i] = mem_oe_n; dq_p[i] = mem_dq_oe;
                ce_p[i] = mem_ce_n; rdy_p[i] = req_ready;
                @(negedge clk);
            end
            chk(we_p == 4'b1001, st ? "R4" : "R3", "write enable pattern", int'(we_p), 9);
            if (st) begin
                chk(oe_p == 4'b0000, "R4", "output enable low pattern (R8 latched style)", int'(oe_p), 0);
                chk(dq_p == 4'b0100, "R4", "late driver pattern", int'(dq_p), 4);
            end else begin
                chk(oe_p == 4'b1111, "R3", "output enable high pattern (R8 latched style)", int'(oe_p), 15);
                chk(dq_p == 4'b1111, "R3", "driver pattern", int'(dq_p), 15);
            end
            chk(ce_p == 4'b0000, "R3", "chip enable pattern", int'(ce_p), 0);
            chk(rdy_p == 4'b0000 && req_ready, "R9", "busy window of write", int'({req_ready, rdy_p}), 16);
        end
    endtask

    task automatic check_idle(input string why);
        chk(req_ready && mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !rd_valid, "R1", why,
            int'({req_ready, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, rd_valid}), 6'b111100);
    endtask

    task automatic finish_run();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        logic [15:0] lf;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_idle("reset state");

        // R3/R4: both write styles at edge addresses and patterns
        issue(1, 15'h0000, 8'h3C, 0);
        issue(1, 15'h7FFF, 8'hC3, 1);
        issue(1, 15'h5555, 8'hFF, 0);
        issue(1, 15'h2AAA, 8'h00, 1);
        // R2: read back, plus an address never written
        issue(0, 15'h0000, 8'h00, 0);
        issue(0, 15'h7FFF, 8'h00, 1);
        issue(0, 15'h5555, 8'h00, 0);
        issue(0, 15'h2AAA, 8'h00, 0);
        issue(0, 15'h1234, 8'h00, 0);
        // R7: read then write at once, then read again; R8 style flipped mid-access
        issue(0, 15'h7FFF, 8'h00, 0);
        issue(1, 15'h7FFF, 8'h81, 0);
        issue(0, 15'h7FFF, 8'h00, 0);
        issue(1, 15'h7FFF, 8'h7E, 1);
        issue(0, 15'h7FFF, 8'h00, 1);

        // Mixed traffic from an LFSR (R2, R3, R4, R9)
        lf = 16'hACE1;
        for (int n = 0; n < 80; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            issue(lf[5], {lf[11:9], 8'h00, lf[3:0]}, lf[15:8], lf[6]);
        end

        repeat (6) @(negedge clk);
        chk(exp_q.size() == 0, "R2", "all reads returned", exp_q.size(), 0);
        check_idle("idle after traffic");
        finish_run();
    end

endmodule